// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Interrupts

This block is a memory-mapped general purpose I/O controller for 64 pins. The pins sit in two register sets of 32 each, reached over a plain 32-bit register bus with an address, a write strobe, write data and combinational read data. Every pin has a direction bit and an output latch. It also has a synchronised input readback and independent rising-edge and falling-edge detectors. The output latch and the edge enables are never written whole: software changes them through separate set-mask and clear-mask words, so two agents can touch different pins without a read-modify-write.

An enabled edge latches a sticky bit in a per-set status word, which software clears by writing ones. The status bits are grouped into four interrupt banks of 16 pins. Each bank drives its own level-sensitive interrupt line, gated by one bit of a shared bank-enable word. Pin output enables are the inverse of the direction bits.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: After reset every direction bit is 1. The output latches, edge enables, status bits and bank enables are 0, all `pin_oe_o` bits are 0 and all `irq_o` lines are low.
- R2: The bank-enable word sits at byte address 0x08 in bits [3:0]. Register set s (0 or 1) starts at 0x10 + 0x28*s. Within a set the word offsets are: 0x00 direction, 0x04 output data, 0x08 set mask, 0x0C clear mask, 0x10 input data, 0x14 rising-enable set, 0x18 rising-enable clear, 0x1C falling-enable set, 0x20 falling-enable clear, 0x24 status. Reads of any other address return 0, and writes to them change nothing.
- R3: A direction bit of 1 makes its pin an input and 0 makes it an output. `pin_oe_o` is the inverse of the direction bits and `pin_o` carries the output latches. Pin n of set s is bit 32*s+n of the pin ports.
- R4: A write to the set-mask word raises each latch whose data bit is 1. A write to the clear-mask word lowers each latch whose data bit is 1. Latches under 0 data bits keep their value. The output-data, set-mask and clear-mask words all read back the latch, and writes to the output-data word are ignored.
- R5: The input-data word returns the pin level after a two-flop synchroniser. A change on `pin_i` becomes readable after the second rising clock edge. This holds whether the pin is an input or an output.
- R6: Writing ones to a rising-enable or falling-enable set word enables that detector for those pins, and writing ones to the matching clear word disables it. Both detectors of one pin may be enabled at once. Each set and clear pair reads back the current enable mask.
- R7: A rising edge (synchronised level 0 then 1 on consecutive cycles) on a pin with its rising detector enabled sets that pin's status bit. A falling edge with the falling detector enabled does the same. The bit becomes readable after the third rising clock edge following the pin change. Edges on pins whose detector is disabled set nothing.
- R8: Writing 1 to a status bit clears it and writing 0 leaves it alone. When an edge is detected in the same cycle as a clearing write to that bit, the bit stays set.
- R9: Status bits [15:0] of set s form bank 2s and bits [31:16] form bank 2s+1. `irq_o[b]` is high exactly while bank-enable bit b is 1 and at least one status bit of bank b is set. It stays high until all of that bank's bits are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 8 | Byte address of the register access |
| we_i | input | 1 | Write strobe, taken at the rising clock edge |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| pin_i | input | 64 | Pin levels, asynchronous to the clock |
| pin_o | output | 64 | Output latch values |
| pin_oe_o | output | 64 | Output enables, 1 drives the pin |
| irq_o | output | 4 | Per-bank interrupt lines |

## Verification
The assertions assume that the bus is quiet while reset is low and that software uses only word-aligned addresses. They also assume `pin_i` holds still for the synchroniser to settle before an edge is expected in the status. The stimulus keeps to this in several ways. It drives bus signals only at falling edges and changes the pins only between transactions. It then waits four cycles after a pin change, so every edge has landed in the status before the model is compared. The one exception is the directed case where a clearing write is timed to land in the same cycle as an edge.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;
  localparam int ADDR_W  = 8;
  localparam int DATA_W  = 32;
  localparam int WORD_IW = 4;

  localparam logic [ADDR_W-1:0] BANK_EN_ADDR = 8'h08;
  localparam logic [ADDR_W-1:0] SET_BASE     = 8'h10;
  localparam logic [ADDR_W-1:0] SET_STRIDE   = 8'h28;
  localparam int                SET_WORDS    = 10;

  typedef enum logic [WORD_IW-1:0] {
    W_DIR      = 4'd0,
    W_OUT      = 4'd1,
    W_SET      = 4'd2,
    W_CLR      = 4'd3,
    W_IN       = 4'd4,
    W_RISE_SET = 4'd5,
    W_RISE_CLR = 4'd6,
    W_FALL_SET = 4'd7,
    W_FALL_CLR = 4'd8,
    W_STAT     = 4'd9
  } word_e;
endpackage

// File: rtl/gpio_edge_sync.sv
module gpio_edge_sync #(
  parameter int WIDTH  = 64,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     stage_q[i] <= '0;
      else if (i == 0) stage_q[i] <= d_i;
      else             stage_q[i] <= stage_q[(i == 0) ? 0 : i-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_edge_portset.sv
module gpio_edge_portset
  import gpio_edge_pkg::*;
#(
  parameter int W = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_i,
  input  logic [WORD_IW-1:0] word_i,
  input  logic [W-1:0]       wdata_i,
  input  logic [W-1:0]       pin_sync_i,
  output logic [W-1:0]       dir_o,
  output logic [W-1:0]       out_o,
  output logic [W-1:0]       status_o,
  output logic [W-1:0]       rdata_o
);
  logic [W-1:0] dir_q, out_q, rise_q, fall_q, stat_q, prev_q;
  logic [W-1:0] edge_v, stat_clr;

  assign edge_v   = (rise_q & pin_sync_i & ~prev_q) | (fall_q & ~pin_sync_i & prev_q);
  assign stat_clr = (wr_i && word_i == W_STAT) ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q  <= '1;
      out_q  <= '0;
      rise_q <= '0;
      fall_q <= '0;
      stat_q <= '0;
      prev_q <= '0;
    end else begin
      prev_q <= pin_sync_i;
      stat_q <= (stat_q & ~stat_clr) | edge_v;  // new edge wins over clear
      if (wr_i) begin
        unique case (word_i)
          W_DIR:      dir_q  <= wdata_i;
          W_SET:      out_q  <= out_q | wdata_i;
          W_CLR:      out_q  <= out_q & ~wdata_i;
          W_RISE_SET: rise_q <= rise_q | wdata_i;
          W_RISE_CLR: rise_q <= rise_q & ~wdata_i;
          W_FALL_SET: fall_q <= fall_q | wdata_i;
          W_FALL_CLR: fall_q <= fall_q & ~wdata_i;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    unique case (word_i)
      W_DIR:                  rdata_o = dir_q;
      W_OUT, W_SET, W_CLR:    rdata_o = out_q;
      W_IN:                   rdata_o = pin_sync_i;
      W_RISE_SET, W_RISE_CLR: rdata_o = rise_q;
      W_FALL_SET, W_FALL_CLR: rdata_o = fall_q;
      W_STAT:                 rdata_o = stat_q;
      default:                rdata_o = '0;
    endcase
  end

  assign dir_o    = dir_q;
  assign out_o    = out_q;
  assign status_o = stat_q;

  a_r3_dir_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && word_i == W_DIR) |=> dir_q == $past(wdata_i));
  a_r4_set_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && word_i == W_SET) |=> (out_q & $past(wdata_i)) == $past(wdata_i));
  a_r4_clear_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && word_i == W_CLR) |=> (out_q & $past(wdata_i)) == '0);
  a_r7_edge_latches: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|edge_v) |=> (stat_q & $past(edge_v)) == $past(edge_v));
  a_r8_w1c_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && word_i == W_STAT) |=> (stat_q & $past(wdata_i & ~edge_v)) == '0);
  a_r8_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && word_i == W_STAT) |=> (stat_q & $past(stat_q)) == $past(stat_q));
endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq #(
  parameter int NUM_BANKS = 4,
  parameter int BANK_W    = 16
) (
  input  logic [NUM_BANKS*BANK_W-1:0] status_i,
  input  logic [NUM_BANKS-1:0]        en_i,
  output logic [NUM_BANKS-1:0]        irq_o
);
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign irq_o[b] = en_i[b] & (|status_i[b*BANK_W +: BANK_W]);
  end
endmodule

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl
  import gpio_edge_pkg::*;
#(
  parameter int NUM_SETS    = 2,
  parameter int BANK_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic                       we_i,
  input  logic [DATA_W-1:0]          wdata_i,
  output logic [DATA_W-1:0]          rdata_o,
  input  logic [NUM_SETS*DATA_W-1:0] pin_i,
  output logic [NUM_SETS*DATA_W-1:0] pin_o,
  output logic [NUM_SETS*DATA_W-1:0] pin_oe_o,
  output logic [NUM_SETS*DATA_W*0+NUM_SETS*DATA_W/BANK_W-1:0] irq_o
);
  localparam int NUM_PINS  = NUM_SETS * DATA_W;
  localparam int NUM_BANKS = NUM_PINS / BANK_W;

  logic [NUM_PINS-1:0]  pin_sync, dir_all, status_all;
  logic [NUM_BANKS-1:0] bank_en_q;
  logic [NUM_SETS-1:0]  hit;
  logic [DATA_W-1:0]    set_rd [NUM_SETS];
  logic                 en_wr;

  gpio_edge_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(pin_i), .q_o(pin_sync)
  );

  for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
    localparam logic [ADDR_W-1:0] BASE = SET_BASE + ADDR_W'(s) * SET_STRIDE;
    logic [ADDR_W-1:0]  rel;
    logic [WORD_IW-1:0] word;
    assign rel    = addr_i - BASE;
    assign word   = WORD_IW'(rel >> 2);
    assign hit[s] = (addr_i >= BASE) && (rel < ADDR_W'(4 * SET_WORDS)) && (addr_i[1:0] == 2'b00);

    gpio_edge_portset #(.W(DATA_W)) u_set (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_i       (we_i && hit[s]),
      .word_i     (word),
      .wdata_i    (wdata_i),
      .pin_sync_i (pin_sync[s*DATA_W +: DATA_W]),
      .dir_o      (dir_all[s*DATA_W +: DATA_W]),
      .out_o      (pin_o[s*DATA_W +: DATA_W]),
      .status_o   (status_all[s*DATA_W +: DATA_W]),
      .rdata_o    (set_rd[s])
    );
  end

  assign pin_oe_o = ~dir_all;
  assign en_wr    = we_i && (addr_i == BANK_EN_ADDR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    bank_en_q <= '0;
    else if (en_wr) bank_en_q <= wdata_i[NUM_BANKS-1:0];
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == BANK_EN_ADDR) rdata_o[NUM_BANKS-1:0] = bank_en_q;
    for (int s = 0; s < NUM_SETS; s++)
      if (hit[s]) rdata_o = set_rd[s];
  end

  gpio_edge_irq #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)) u_irq (
    .status_i (status_all),
    .en_i     (bank_en_q),
    .irq_o    (irq_o)
  );

  a_r2_bank_en_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_wr |=> bank_en_q == $past(wdata_i[NUM_BANKS-1:0]));
  a_r2_single_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({hit, addr_i == BANK_EN_ADDR}));

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_irq_chk
    a_r9_irq_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o[b] |-> (bank_en_q[b] && (|status_all[b*BANK_W +: BANK_W])));
  end
endmodule

// File: tb/gpio_edge_ctrl_tb_top.sv
module gpio_edge_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [63:0] pin_i = '0;
  logic [63:0] pin_o, pin_oe;
  logic [3:0]  irq;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic [31:0] m_dir [2], m_out [2], m_rise [2], m_fall [2], m_stat [2];
  logic [3:0]  m_en;
  logic [63:0] m_pin;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_edge_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .rdata_o(rdata), .pin_i(pin_i), .pin_o(pin_o), .pin_oe_o(pin_oe), .irq_o(irq)
  );

  function automatic logic [7:0] wa(int s, int w);
    return 8'(8'h10 + s * 8'h28 + w * 4);
  endfunction

  function automatic logic [3:0] exp_irq();
    logic [3:0] r;
    for (int b = 0; b < 4; b++) r[b] = m_en[b] & (|m_stat[b/2][16*(b%2) +: 16]);
    return r;
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(posedge clk); #1 we = 1'b0;
  endtask

  task automatic bus_rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; we = 1'b0; #1 d = rdata;
  endtask

  task automatic check_regs(string tag);
    logic [31:0] v;
    for (int s = 0; s < 2; s++) begin
      bus_rd(wa(s, 0), v); chk({tag, " R3 dir"}, 64'(v), 64'(m_dir[s]));
      bus_rd(wa(s, 1), v); chk({tag, " R4 out"}, 64'(v), 64'(m_out[s]));
      bus_rd(wa(s, 5), v); chk({tag, " R6 rise"}, 64'(v), 64'(m_rise[s]));
      bus_rd(wa(s, 7), v); chk({tag, " R6 fall"}, 64'(v), 64'(m_fall[s]));
      bus_rd(wa(s, 9), v); chk({tag, " R8 stat"}, 64'(v), 64'(m_stat[s]));
    end
    chk({tag, " R3 pin_o"}, pin_o, {m_out[1], m_out[0]});
    chk({tag, " R3 pin_oe"}, pin_oe, ~{m_dir[1], m_dir[0]});
    chk({tag, " R9 irq"}, 64'(irq), 64'(exp_irq()));
  endtask

  // drive new pin levels and let edges settle into the status
  task automatic move_pins(logic [63:0] v);
    logic [31:0] o, n;
    @(negedge clk); pin_i = v;
    repeat (4) @(posedge clk);
    for (int s = 0; s < 2; s++) begin
      o = m_pin[32*s +: 32]; n = v[32*s +: 32];
      m_stat[s] |= (m_rise[s] & n & ~o) | (m_fall[s] & ~n & o);
    end
    m_pin = v;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, d;
    int s, op;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 2; i++) begin
      m_dir[i] = '1; m_out[i] = '0; m_rise[i] = '0; m_fall[i] = '0; m_stat[i] = '0;
    end
    m_en = '0; m_pin = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    check_regs("R1 reset");
    bus_rd(8'h08, v); chk("R1 bank enable", 64'(v), 64'h0);

    // R2 unmapped addresses read 0 and writes change nothing
    bus_wr(8'h00, 32'hFFFF_FFFF);
    bus_wr(8'h60, 32'hFFFF_FFFF);
    bus_rd(8'h00, v); chk("R2 unmapped 0x00", 64'(v), 64'h0);
    bus_rd(8'h60, v); chk("R2 unmapped 0x60", 64'(v), 64'h0);
    bus_rd(8'h0C, v); chk("R2 unmapped 0x0C", 64'(v), 64'h0);
    check_regs("R2 after stray writes");

    // R4 write to output-data word is ignored
    bus_wr(wa(0, 1), 32'hDEAD_BEEF);
    bus_rd(wa(0, 1), v); chk("R4 out word ignored", 64'(v), 64'(m_out[0]));
    bus_wr(wa(1, 2), 32'h0000_F00F); m_out[1] |= 32'h0000_F00F;
    bus_rd(wa(1, 3), v); chk("R4 clear word readback", 64'(v), 64'(m_out[1]));

    // R5 input readback timing, pin driven as output
    bus_wr(wa(0, 0), 32'h0); m_dir[0] = '0;
    @(negedge clk); pin_i[5] = 1'b1; addr = wa(0, 4);
    @(posedge clk); #1 chk("R5 not yet after one edge", 64'(rdata[5]), 64'h0);
    @(posedge clk); #1 chk("R5 visible after two edges", 64'(rdata[5]), 64'h1);
    repeat (2) @(posedge clk);
    m_pin = pin_i;

    // R7 disabled detector sets nothing
    move_pins(64'h0);
    bus_rd(wa(0, 9), v); chk("R7 no status when disabled", 64'(v), 64'h0);

    // R8 edge and clear in same cycle: edge wins
    bus_wr(wa(0, 5), 32'h1); m_rise[0] |= 32'h1;
    bus_wr(wa(0, 9), 32'h1);
    @(negedge clk); pin_i[0] = 1'b1;
    @(posedge clk); @(posedge clk);
    bus_wr(wa(0, 9), 32'h1);
    bus_rd(wa(0, 9), v); chk("R8 edge beats clear", 64'(v[0]), 64'h1);
    m_pin = pin_i; m_stat[0] |= 32'h1;
    bus_wr(wa(0, 9), 32'h0);
    bus_rd(wa(0, 9), v); chk("R8 zero write no effect", 64'(v[0]), 64'h1);
    bus_wr(wa(0, 9), 32'h1); m_stat[0] &= ~32'h1;
    bus_rd(wa(0, 9), v); chk("R8 one write clears", 64'(v[0]), 64'h0);

    // R9 bank 1 (set 0 upper half) irq with enable
    bus_wr(wa(0, 7), 32'h0001_0000); m_fall[0] |= 32'h0001_0000;
    move_pins(m_pin | 64'h0001_0000);
    move_pins(m_pin & ~64'h0001_0000);
    chk("R9 pending but disabled", 64'(irq), 64'h0);
    bus_wr(8'h08, 32'h2); m_en = 4'h2;
    #1 chk("R9 bank1 irq", 64'(irq), 64'h2);
    bus_wr(wa(0, 9), 32'h0001_0000); m_stat[0] = '0;
    #1 chk("R9 irq drops after clear", 64'(irq), 64'h0);

    // random register traffic (R3 R4 R6)
    for (int i = 0; i < 200; i++) begin
      s = int'($urandom_range(1, 0)); op = int'($urandom_range(7, 0)); d = $urandom;
      case (op)
        0: begin bus_wr(wa(s, 0), d); m_dir[s] = d; end
        1: begin bus_wr(wa(s, 2), d); m_out[s] |= d; end
        2: begin bus_wr(wa(s, 3), d); m_out[s] &= ~d; end
        3: begin bus_wr(wa(s, 5), d); m_rise[s] |= d; end
        4: begin bus_wr(wa(s, 6), d); m_rise[s] &= ~d; end
        5: begin bus_wr(wa(s, 7), d); m_fall[s] |= d; end
        6: begin bus_wr(wa(s, 8), d); m_fall[s] &= ~d; end
        default: bus_wr(wa(s, 1), d);
      endcase
      if (i % 20 == 19) check_regs("R4 R6 random");
    end

    // random pin edges, enables and clears (R7 R8 R9 R5)
    for (int i = 0; i < 150; i++) begin
      move_pins({$urandom, $urandom});
      if (i % 5 == 0) begin d = $urandom; bus_wr(8'h08, d); m_en = d[3:0]; end
      if (i % 3 == 0) begin
        s = int'($urandom_range(1, 0)); d = $urandom;
        bus_wr(wa(s, 9), d); m_stat[s] &= ~d;
      end
      if (i % 4 == 0) begin
        s = int'($urandom_range(1, 0));
        bus_rd(wa(s, 4), v); chk("R5 input data", 64'(v), 64'(m_pin[32*s +: 32]));
        bus_rd(wa(s, 9), v); chk("R7 status", 64'(v), 64'(m_stat[s]));
        chk("R9 irq random", 64'(irq), 64'(exp_irq()));
      end
    end
    check_regs("R7 R9 final");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule